// File: doc/BRIEF.md
# Register Lock Scoreboard

This block guards the register file of a floating-point coprocessor pipeline against read-after-write, write-after-read and write-after-write hazards. It keeps two lock tables with one bit per single-precision register. One table holds locks for registers that a pending operation still has to read. The other holds locks for registers that a pending operation still has to write. A double-precision register takes up two adjacent bits.

The decode logic supplies a source mask and a destination mask for the instruction waiting at issue. For a vector operation, these masks already cover every iteration. Issue is granted in the same cycle only if none of the requested registers is locked in either table. On a grant, every requested register is locked in one step. On a stall, neither table gains a lock, and the instruction simply presents its masks again on the next cycle.

The surrounding pipeline releases locks as its stages progress. It can do this with a mask pulse per table. It can also give a register index, with a flag that widens the release to a double-precision pair.

Top module: `reg_lock_board`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), both tables are cleared. `iss_grant` is 0 whenever `iss_valid` is 0.
- R2: `iss_grant` is combinational. It is 1 exactly when `iss_valid` is 1 and the OR of both request masks shares no bit with the OR of both tables. A source lock therefore blocks a destination request, and a destination lock blocks a source request.
- R3: When the request is not granted, neither table gains a bit on the next edge.
- R4: On a grant, every bit of `iss_src_mask` is set in the source table and every bit of `iss_dst_mask` is set in the destination table on the next edge. All bits are set together.
- R5: A 1 in `src_clr_mask` or `dst_clr_mask` releases that bit in its own table only, on the next edge.
- R6: An index release with its valid bit set and `dbl`=0 releases bit `idx`. With `dbl`=1 it releases bits `idx & ~1` and `(idx & ~1) + 1`.
- R7: If a grant sets a bit in the same cycle that a release clears it, the bit is set afterwards.
- R8: The grant decision uses the tables as they stand before this cycle's releases. A release in the same cycle does not turn a stall into a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is waiting at issue |
| iss_src_mask | input | NREG | Registers it reads, all iterations |
| iss_dst_mask | input | NREG | Registers it writes, all iterations |
| iss_grant | output | 1 | Issue granted this cycle |
| src_clr_mask | input | NREG | Source lock release mask |
| dst_clr_mask | input | NREG | Destination lock release mask |
| src_clr_vld | input | 1 | Source index release valid |
| src_clr_idx | input | IW | Source index to release |
| src_clr_dbl | input | 1 | Source release covers a register pair |
| dst_clr_vld | input | 1 | Destination index release valid |
| dst_clr_idx | input | IW | Destination index to release |
| dst_clr_dbl | input | 1 | Destination release covers a register pair |
| src_locks | output | NREG | Current source table |
| dst_locks | output | NREG | Current destination table |

## Verification
A lock set and a lock release can fall in the same cycle. This happens either on the same bit, or on a bit that the waiting instruction is stalled on. Directed steps provoke both cases. A granted request sets a bit while that bit's release pulse is driven. A stalled request sees its blocking bit released in the same cycle. The outcome is judged against R7 (the bit stays set) and R8 (the stall holds for that cycle). A long stretch of sparse random masks and releases then lets such collisions arise freely, with a behavioural model compared on every cycle.

// File: rtl/reg_lock_board.sv
module reg_lock_board #(
  parameter int NREG = 32,
  parameter int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [NREG-1:0] iss_src_mask,
  input  logic [NREG-1:0] iss_dst_mask,
  output logic            iss_grant,
  input  logic [NREG-1:0] src_clr_mask,
  input  logic [NREG-1:0] dst_clr_mask,
  input  logic            src_clr_vld,
  input  logic [IW-1:0]   src_clr_idx,
  input  logic            src_clr_dbl,
  input  logic            dst_clr_vld,
  input  logic [IW-1:0]   dst_clr_idx,
  input  logic            dst_clr_dbl,
  output logic [NREG-1:0] src_locks,
  output logic [NREG-1:0] dst_locks
);

  function automatic logic [NREG-1:0] idx_mask(input logic v, input logic [IW-1:0] idx,
                                              input logic dbl);
    logic [NREG-1:0] m;
    logic [IW-1:0] base;
    m = '0;
    base = dbl ? (idx & ~IW'(1)) : idx;
    if (v) begin
      m[base] = 1'b1;
      if (dbl) m[base | IW'(1)] = 1'b1;
    end
    return m;
  endfunction

  logic [NREG-1:0] src_q, dst_q;
  logic [NREG-1:0] src_rel, dst_rel;

  assign iss_grant = iss_valid && (((iss_src_mask | iss_dst_mask) & (src_q | dst_q)) == '0);
  assign src_rel   = src_clr_mask | idx_mask(src_clr_vld, src_clr_idx, src_clr_dbl);
  assign dst_rel   = dst_clr_mask | idx_mask(dst_clr_vld, dst_clr_idx, dst_clr_dbl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else begin
      src_q <= (src_q & ~src_rel) | (iss_grant ? iss_src_mask : '0);
      dst_q <= (dst_q & ~dst_rel) | (iss_grant ? iss_dst_mask : '0);
    end
  end

  assign src_locks = src_q;
  assign dst_locks = dst_q;

endmodule

module reg_lock_board_chk #(
  parameter int NREG = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_grant,
  input logic [NREG-1:0] iss_src_mask,
  input logic [NREG-1:0] iss_dst_mask,
  input logic [NREG-1:0] src_clr_mask,
  input logic [NREG-1:0] dst_clr_mask,
  input logic [NREG-1:0] src_locks,
  input logic [NREG-1:0] dst_locks
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (src_locks == '0 && dst_locks == '0));

  // R1
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !iss_grant);

  // R2
  grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_grant |-> (((iss_src_mask | iss_dst_mask) & (src_locks | dst_locks)) == '0));

  // R3
  stall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_grant |=> ((src_locks & ~$past(src_locks)) == '0));

  // R3
  stall_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_grant |=> ((dst_locks & ~$past(dst_locks)) == '0));

  // R4
  grant_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_grant |=> (((src_locks & $past(iss_src_mask)) == $past(iss_src_mask)) &&
                   ((dst_locks & $past(iss_dst_mask)) == $past(iss_dst_mask))));

  // R5
  src_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_grant |=> ((src_locks & $past(src_clr_mask)) == '0));

  // R5
  dst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_grant |=> ((dst_locks & $past(dst_clr_mask)) == '0));

endmodule

bind reg_lock_board reg_lock_board_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_grant(iss_grant),
  .iss_src_mask(iss_src_mask), .iss_dst_mask(iss_dst_mask),
  .src_clr_mask(src_clr_mask), .dst_clr_mask(dst_clr_mask),
  .src_locks(src_locks), .dst_locks(dst_locks)
);

// File: tb/test_reg_lock_board.sv
module test_reg_lock_board;
  localparam int N = 32;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_grant;
  logic [N-1:0] iss_src_mask = '0, iss_dst_mask = '0, src_clr_mask = '0, dst_clr_mask = '0;
  logic src_clr_vld = 0, src_clr_dbl = 0, dst_clr_vld = 0, dst_clr_dbl = 0;
  logic [4:0] src_clr_idx = '0, dst_clr_idx = '0;
  logic [N-1:0] src_locks, dst_locks;

  int total = 0, bad = 0;
  bit ms[N], md[N];

  always #2.5 clk = ~clk;

  reg_lock_board #(.NREG(N)) i_reg_lock_board (.*);

  function automatic bit exp_grant();
    if (!iss_valid) return 0;
    for (int i = 0; i < N; i++)
      if ((iss_src_mask[i] || iss_dst_mask[i]) && (ms[i] || md[i])) return 0;
    return 1;
  endfunction

  function automatic bit rel_hit(bit v, int idx, bit dbl, int i);
    if (!v) return 0;
    if (dbl) return (i / 2) == (idx / 2);
    return i == idx;
  endfunction

  function automatic logic [N-1:0] pack(bit a[N]);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = a[i];
    return r;
  endfunction

  task automatic check(string tag, string what, logic [N-1:0] got, logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag);
    bit g;
    #1;
    g = exp_grant();
    check(tag, "grant", {{(N-1){1'b0}}, iss_grant}, {{(N-1){1'b0}}, g});
    check(tag, "src_locks", src_locks, pack(ms));
    check(tag, "dst_locks", dst_locks, pack(md));
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      bit rs, rd;
      rs = src_clr_mask[i] || rel_hit(src_clr_vld, int'(src_clr_idx), src_clr_dbl, i);
      rd = dst_clr_mask[i] || rel_hit(dst_clr_vld, int'(dst_clr_idx), dst_clr_dbl, i);
      ms[i] = (ms[i] && !rs) || (g && iss_src_mask[i]);
      md[i] = (md[i] && !rd) || (g && iss_dst_mask[i]);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = 0; iss_src_mask = '0; iss_dst_mask = '0;
    src_clr_mask = '0; dst_clr_mask = '0;
    src_clr_vld = 0; dst_clr_vld = 0; src_clr_dbl = 0; dst_clr_dbl = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "grant in reset", {{(N-1){1'b0}}, iss_grant}, '0);
    check("R1", "src reset", src_locks, '0);
    check("R1", "dst reset", dst_locks, '0);
    rst_n = 1;
    step("R1");

    iss_valid = 1; iss_src_mask = 32'h6; iss_dst_mask = 32'h8;
    step("R4");
    idle();
    iss_valid = 1; iss_dst_mask = 32'h4;
    step("R3");
    iss_src_mask = 32'h8; iss_dst_mask = '0;
    step("R2");
    iss_dst_mask = 32'h8; iss_src_mask = '0; dst_clr_mask = 32'h8;
    step("R8");
    idle();
    src_clr_vld = 1; src_clr_idx = 5'd1;
    step("R6");
    idle();
    iss_valid = 1; iss_dst_mask = 32'h30;
    step("R4");
    idle();
    dst_clr_vld = 1; dst_clr_idx = 5'd5; dst_clr_dbl = 1;
    step("R6");
    idle();
    iss_valid = 1; iss_src_mask = 32'h400; src_clr_mask = 32'h400;
    step("R7");
    idle();
    src_clr_mask = 32'h4; dst_clr_mask = 32'h400;
    step("R5");
    idle();
    src_clr_mask = '1; dst_clr_mask = '1;
    step("R5");
    idle();

    for (int k = 0; k < 3000; k++) begin
      iss_valid    = $urandom_range(0, 3) != 0;
      iss_src_mask = $urandom & $urandom & $urandom;
      iss_dst_mask = $urandom & $urandom & $urandom & $urandom;
      src_clr_mask = $urandom & $urandom & $urandom;
      dst_clr_mask = $urandom & $urandom & $urandom;
      src_clr_vld  = $urandom_range(0, 1) == 1;
      dst_clr_vld  = $urandom_range(0, 1) == 1;
      src_clr_idx  = 5'($urandom);
      dst_clr_idx  = 5'($urandom);
      src_clr_dbl  = $urandom_range(0, 1) == 1;
      dst_clr_dbl  = $urandom_range(0, 1) == 1;
      step("R2");
    end
    idle();
    step("R5");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule